// File: doc/BRIEF.md
# Multi-Port L1 Data Line Array

A set-associative array of cache lines that serves several request ports in the same clock cycle. Every port can send one request per cycle. A request can be a plain lookup, a lookup that also rewrites the stored 8-bit state of a line, or an insert that installs a whole line with its tag and state. Every accepted request gets its response exactly one cycle later. The response holds an echoed sequence token, the address, the resulting line state and, when the request asked for it, the line data.

Storage is split into banks by the low bits of the set index. Each bank holds one single-port SRAM per way, and all ways of a set are read at once. Tag and data come out of the same read, so a hit needs no second access. When two ports target the same bank in one cycle, the lower-numbered port proceeds and the other port sees its availability signal drop. A bank that has just accepted a write-type request stays closed to new requests for the following cycle, because that cycle performs the write. Fetching missing lines from further down the hierarchy is the job of the surrounding logic.

Top module: `l1d_line_array`

## Requirements
- R1: Lines are 64 bytes. Address bits [15:6] select one of 1024 sets, bits [63:16] form the tag, and bits [5:0] are ignored for matching. The bank is the set index modulo the bank count, which is address bit 6 with two banks.
- R2: A request that is enabled while its port-available signal is high gets a response one cycle later, with respReady high and respAddr equal to the request address. Any other cycle shows respReady low.
- R3: Tokens count accepted requests from 0 after reset. Requests accepted in the same cycle take consecutive values in ascending port order.
- R4: A lookup that hits returns the stored state. It also returns the stored line, but only when needs-data is high. With needs-data low, respData is all zeros.
- R5: A lookup that finds no valid frame with a matching tag returns state 0 and all-zero data. State 0 means invalid.
- R6: An insert with a nonzero state writes the tag and the state and returns the new state. With has-data high it stores the supplied line. With has-data low it keeps the line of the frame it hits, or stores zeros when it misses.
- R7: An insert that misses uses the lowest-numbered invalid way of the set. If no way is invalid, it uses a per-bank round-robin victim pointer that starts at way 0 and advances after each such eviction.
- R8: A non-insert request with the update-state flag rewrites the state of a hitting frame and returns the new state. On a miss it changes nothing and returns state 0.
- R9: An insert with state 0 invalidates the frame with the matching tag and returns state 0. Later lookups of that tag miss.
- R10: When two enabled ports target the same bank, only the lower-numbered port is available. The higher port gets no response for that request.
- R11: In the cycle after a bank accepts an insert or an update-state request, every port that addresses that bank is unavailable. Ports that address other banks are not affected.
- R12: After reset no response is pending, every frame is invalid and every idle port is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqEn | input | NUM_PORTS | Request valid, one bit per port |
| reqInsert | input | NUM_PORTS | Request installs a line |
| reqHasData | input | NUM_PORTS | Insert carries line data |
| reqNeedsData | input | NUM_PORTS | Response must carry the line |
| reqUpdState | input | NUM_PORTS | Non-insert request rewrites the state on a hit |
| reqNewState | input | NUM_PORTS x 8 | State to write |
| reqAddr | input | NUM_PORTS x 64 | Byte address |
| reqData | input | NUM_PORTS x 512 | Line to insert |
| portAvail | output | NUM_PORTS | Port can accept a request this cycle |
| respReady | output | NUM_PORTS | Response valid |
| respToken | output | NUM_PORTS x 64 | Sequence token of the request |
| respAddr | output | NUM_PORTS x 64 | Echoed address |
| respState | output | NUM_PORTS x 8 | Resulting line state, 0 on a miss |
| respData | output | NUM_PORTS x 512 | Line data or zeros |

## Verification
The checker watches the port-level protocol on every cycle. It checks that a response follows each grant and nothing else, that the address comes back unchanged, that a lower port blocks a higher port on the same bank, that tokens are ordered between ports responding together, and that misses and requests without needs-data return zero data. What is stored cannot be seen by a per-cycle property. The bench scenarios therefore cover hit contents, way choice and round-robin eviction, state rewrites, invalidation, keeping data on an insert without data, and the bank-busy cycle after a write.

// File: rtl/l1d_pkg.sv
`timescale 1ns/1ps
package l1d_pkg;
  localparam int ADDR_W     = 64;
  localparam int STATE_W    = 8;
  localparam int TOKEN_W    = 64;
  localparam int OFFSET_LSB = 6;
  localparam int INDEX_W    = 10;
  localparam int TAG_W      = ADDR_W - OFFSET_LSB - INDEX_W;
  localparam int LINE_BITS  = 8 << OFFSET_LSB;

  // read strobe from control to one bank
  typedef struct packed {
    logic               rdEn;
    logic [INDEX_W-1:0] setIdx;
  } bankStrobe_t;

  // request held for the cycle in which it is resolved
  typedef struct packed {
    logic               valid;
    logic               isInsert;
    logic               hasData;
    logic               needsData;
    logic               updState;
    logic [STATE_W-1:0] newState;
    logic [ADDR_W-1:0]  addr;
    logic [TOKEN_W-1:0] token;
  } stageReq_t;
endpackage

// File: rtl/l1d_way_sram.sv
`timescale 1ns/1ps
module l1d_way_sram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= din;
      else    dout      <= mem[addr];
    end
  end
endmodule

// File: rtl/l1d_ctrl.sv
`timescale 1ns/1ps
module l1d_ctrl
  import l1d_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                reqEn,
  input  logic [NUM_PORTS-1:0]                reqInsert,
  input  logic [NUM_PORTS-1:0]                reqHasData,
  input  logic [NUM_PORTS-1:0]                reqNeedsData,
  input  logic [NUM_PORTS-1:0]                reqUpdState,
  input  logic [NUM_PORTS-1:0][STATE_W-1:0]   reqNewState,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PORTS-1:0][LINE_BITS-1:0] reqData,
  output logic [NUM_PORTS-1:0]                portAvail,
  output bankStrobe_t                         strobe    [NUM_BANKS],
  output stageReq_t                           stage     [NUM_PORTS],
  output logic [NUM_PORTS-1:0][LINE_BITS-1:0] stageData
);
  function automatic logic [BANK_W-1:0] bankOf(input logic [ADDR_W-1:0] a);
    return BANK_W'(a[OFFSET_LSB +: INDEX_W] % NUM_BANKS);
  endfunction

  logic [NUM_BANKS-1:0] busy, claimed;
  logic [BANK_W-1:0]    reqBank [NUM_PORTS];
  logic [NUM_PORTS-1:0] grant;
  logic [TOKEN_W-1:0]   tokOff  [NUM_PORTS];
  logic [TOKEN_W-1:0]   grantCnt, seq;

  always_comb begin
    busy = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (stage[p].valid && (stage[p].isInsert || stage[p].updState))
        busy[bankOf(stage[p].addr)] = 1'b1;
    claimed  = '0;
    grantCnt = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      reqBank[p]   = bankOf(reqAddr[p]);
      portAvail[p] = !busy[reqBank[p]] && !claimed[reqBank[p]];
      grant[p]     = reqEn[p] && portAvail[p];
      tokOff[p]    = grantCnt;
      if (grant[p]) grantCnt = grantCnt + 1'b1;
      if (reqEn[p]) claimed[reqBank[p]] = 1'b1;
    end
    for (int b = 0; b < NUM_BANKS; b++) strobe[b] = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (grant[p]) begin
        strobe[reqBank[p]].rdEn   = 1'b1;
        strobe[reqBank[p]].setIdx = reqAddr[p][OFFSET_LSB +: INDEX_W];
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seq <= '0;
      for (int p = 0; p < NUM_PORTS; p++) stage[p] <= '0;
      stageData <= '0;
    end else begin
      seq <= seq + grantCnt;
      for (int p = 0; p < NUM_PORTS; p++) begin
        stage[p].valid <= grant[p];
        if (grant[p]) begin
          stage[p].isInsert  <= reqInsert[p];
          stage[p].hasData   <= reqHasData[p];
          stage[p].needsData <= reqNeedsData[p];
          stage[p].updState  <= reqUpdState[p];
          stage[p].newState  <= reqNewState[p];
          stage[p].addr      <= reqAddr[p];
          stage[p].token     <= seq + tokOff[p];
          stageData[p]       <= reqData[p];
        end
      end
    end
  end
endmodule

// File: rtl/l1d_datapath.sv
`timescale 1ns/1ps
module l1d_datapath
  import l1d_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 2,
  parameter int NUM_WAYS  = 2,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BANK_SH = $clog2(NUM_BANKS),
  localparam int ROWS   = (1 << INDEX_W) / NUM_BANKS,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int WORD_W = TAG_W + STATE_W + LINE_BITS
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  bankStrobe_t                         strobe    [NUM_BANKS],
  input  stageReq_t                           stage     [NUM_PORTS],
  input  logic [NUM_PORTS-1:0][LINE_BITS-1:0] stageData,
  output logic [NUM_PORTS-1:0]                respReady,
  output logic [NUM_PORTS-1:0][TOKEN_W-1:0]   respToken,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]    respAddr,
  output logic [NUM_PORTS-1:0][STATE_W-1:0]   respState,
  output logic [NUM_PORTS-1:0][LINE_BITS-1:0] respData
);
  localparam int DATA_LSB  = 0;
  localparam int STATE_LSB = LINE_BITS;
  localparam int TAG_LSB   = LINE_BITS + STATE_W;

  logic [WORD_W-1:0] dout      [NUM_BANKS][NUM_WAYS];
  logic              readValid [NUM_BANKS][NUM_WAYS];
  logic [ROWS-1:0]   validBits [NUM_BANKS][NUM_WAYS];
  logic [WAY_W-1:0]  victimPtr [NUM_BANKS];
  logic [ROW_W-1:0]  rdRow     [NUM_BANKS];

  // per-port write intent
  logic              pWrEn  [NUM_PORTS];
  logic [BANK_W-1:0] pBank  [NUM_PORTS];
  logic [WAY_W-1:0]  pWay   [NUM_PORTS];
  logic [ROW_W-1:0]  pRow   [NUM_PORTS];
  logic [WORD_W-1:0] pWord  [NUM_PORTS];
  logic              pValid [NUM_PORTS];
  logic              pAdv   [NUM_PORTS];

  // per-bank write merged from ports
  logic              wrEn    [NUM_BANKS];
  logic [WAY_W-1:0]  wrWay   [NUM_BANKS];
  logic [ROW_W-1:0]  wrRow   [NUM_BANKS];
  logic [WORD_W-1:0] wrWord  [NUM_BANKS];
  logic              wrValid [NUM_BANKS];
  logic              advance [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign rdRow[b] = ROW_W'(strobe[b].setIdx >> BANK_SH);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic wSel;
      assign wSel = wrEn[b] && (wrWay[b] == WAY_W'(w));
      l1d_way_sram #(.WIDTH(WORD_W), .DEPTH(ROWS)) u_sram (
        .clk (clk),
        .en  (strobe[b].rdEn || wSel),
        .we  (wSel),
        .addr(wSel ? wrRow[b] : rdRow[b]),
        .din (wrWord[b]),
        .dout(dout[b][w])
      );
      always_ff @(posedge clk) begin
        if (!rstN) begin
          validBits[b][w] <= '0;
          readValid[b][w] <= 1'b0;
        end else begin
          if (wSel) validBits[b][w][wrRow[b]] <= wrValid[b];
          if (strobe[b].rdEn) readValid[b][w] <= validBits[b][w][rdRow[b]];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rstN) victimPtr[b] <= '0;
      else if (advance[b])
        victimPtr[b] <= (victimPtr[b] == WAY_W'(NUM_WAYS - 1)) ? '0 : victimPtr[b] + 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [BANK_W-1:0]    bk;
    logic [TAG_W-1:0]     tag;
    logic [STATE_W-1:0]   st, oldState, rState;
    logic                 anyHit, anyFree;
    logic [WAY_W-1:0]     hitW, freeW;
    logic [WORD_W-1:0]    oldWord;
    logic [LINE_BITS-1:0] oldLine, newLine, rLine;

    always_comb begin
      bk      = BANK_W'(stage[p].addr[OFFSET_LSB +: INDEX_W] % NUM_BANKS);
      tag     = stage[p].addr[ADDR_W-1 -: TAG_W];
      anyHit  = 1'b0; hitW  = '0;
      anyFree = 1'b0; freeW = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        st = readValid[bk][w] ? dout[bk][w][STATE_LSB +: STATE_W] : '0;
        if (st != '0 && dout[bk][w][TAG_LSB +: TAG_W] == tag && !anyHit) begin
          anyHit = 1'b1; hitW = WAY_W'(w);
        end
        if (st == '0 && !anyFree) begin
          anyFree = 1'b1; freeW = WAY_W'(w);
        end
      end
      oldWord  = dout[bk][hitW];
      oldState = oldWord[STATE_LSB +: STATE_W];
      oldLine  = oldWord[DATA_LSB +: LINE_BITS];
      newLine  = stage[p].hasData ? stageData[p] : (anyHit ? oldLine : '0);

      pBank[p]  = bk;
      pRow[p]   = ROW_W'(stage[p].addr[OFFSET_LSB +: INDEX_W] >> BANK_SH);
      pWrEn[p]  = 1'b0;
      pWay[p]   = hitW;
      pWord[p]  = oldWord;
      pValid[p] = 1'b0;
      pAdv[p]   = 1'b0;
      rState    = anyHit ? oldState : '0;
      rLine     = oldLine;
      if (stage[p].isInsert) begin
        if (stage[p].newState != '0) begin
          pWrEn[p]  = 1'b1;
          pWay[p]   = anyHit ? hitW : (anyFree ? freeW : victimPtr[bk]);
          pWord[p]  = {tag, stage[p].newState, newLine};
          pValid[p] = 1'b1;
          pAdv[p]   = !anyHit && !anyFree;
          rState    = stage[p].newState;
          rLine     = newLine;
        end else begin
          pWrEn[p]  = anyHit;
          pWord[p]  = {tag, {STATE_W{1'b0}}, oldLine};
          rState    = '0;
        end
      end else if (stage[p].updState && anyHit) begin
        pWrEn[p]  = 1'b1;
        pWord[p]  = {tag, stage[p].newState, oldLine};
        pValid[p] = stage[p].newState != '0;
        rState    = stage[p].newState;
      end
      pWrEn[p] = pWrEn[p] && stage[p].valid;
      pAdv[p]  = pAdv[p] && stage[p].valid;

      respReady[p] = stage[p].valid;
      respToken[p] = stage[p].token;
      respAddr[p]  = stage[p].addr;
      respState[p] = stage[p].valid ? rState : '0;
      respData[p]  = (stage[p].valid && stage[p].needsData && rState != '0) ? rLine : '0;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      wrEn[b] = 1'b0; wrWay[b] = '0; wrRow[b] = '0;
      wrWord[b] = '0; wrValid[b] = 1'b0; advance[b] = 1'b0;
    end
    for (int p = 0; p < NUM_PORTS; p++)
      if (pWrEn[p]) begin
        wrEn[pBank[p]]    = 1'b1;
        wrWay[pBank[p]]   = pWay[p];
        wrRow[pBank[p]]   = pRow[p];
        wrWord[pBank[p]]  = pWord[p];
        wrValid[pBank[p]] = pValid[p];
        advance[pBank[p]] = pAdv[p];
      end
  end
endmodule

// File: rtl/l1d_line_array.sv
`timescale 1ns/1ps
module l1d_line_array
  import l1d_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 2,
  parameter int NUM_WAYS  = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                reqEn,
  input  logic [NUM_PORTS-1:0]                reqInsert,
  input  logic [NUM_PORTS-1:0]                reqHasData,
  input  logic [NUM_PORTS-1:0]                reqNeedsData,
  input  logic [NUM_PORTS-1:0]                reqUpdState,
  input  logic [NUM_PORTS-1:0][STATE_W-1:0]   reqNewState,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    reqAddr,
  input  logic [NUM_PORTS-1:0][LINE_BITS-1:0] reqData,
  output logic [NUM_PORTS-1:0]                portAvail,
  output logic [NUM_PORTS-1:0]                respReady,
  output logic [NUM_PORTS-1:0][TOKEN_W-1:0]   respToken,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]    respAddr,
  output logic [NUM_PORTS-1:0][STATE_W-1:0]   respState,
  output logic [NUM_PORTS-1:0][LINE_BITS-1:0] respData
);
  bankStrobe_t                         strobe [NUM_BANKS];
  stageReq_t                           stage  [NUM_PORTS];
  logic [NUM_PORTS-1:0][LINE_BITS-1:0] stageData;

  l1d_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqEn(reqEn), .reqInsert(reqInsert),
    .reqHasData(reqHasData), .reqNeedsData(reqNeedsData),
    .reqUpdState(reqUpdState), .reqNewState(reqNewState),
    .reqAddr(reqAddr), .reqData(reqData), .portAvail(portAvail),
    .strobe(strobe), .stage(stage), .stageData(stageData)
  );

  l1d_datapath #(.NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS), .NUM_WAYS(NUM_WAYS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stage(stage),
    .stageData(stageData), .respReady(respReady), .respToken(respToken),
    .respAddr(respAddr), .respState(respState), .respData(respData)
  );
endmodule

// File: rtl/l1d_line_array_checker.sv
`timescale 1ns/1ps
module l1d_line_array_checker
  import l1d_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_BANKS = 2
) (
  input logic                                clk,
  input logic                                rstN,
  input logic [NUM_PORTS-1:0]                reqEn,
  input logic [NUM_PORTS-1:0]                reqNeedsData,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]    reqAddr,
  input logic [NUM_PORTS-1:0]                portAvail,
  input logic [NUM_PORTS-1:0]                respReady,
  input logic [NUM_PORTS-1:0][TOKEN_W-1:0]   respToken,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0]    respAddr,
  input logic [NUM_PORTS-1:0][STATE_W-1:0]   respState,
  input logic [NUM_PORTS-1:0][LINE_BITS-1:0] respData
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    assert_resp_after_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
      (reqEn[p] && portAvail[p]) |=> respReady[p]);
    assert_no_resp_without_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(reqEn[p] && portAvail[p]) |=> !respReady[p]);
    assert_addr_echo_R2: assert property (@(posedge clk) disable iff (!rstN)
      (reqEn[p] && portAvail[p]) |=> respAddr[p] == $past(reqAddr[p]));
    assert_miss_no_data_R5: assert property (@(posedge clk) disable iff (!rstN)
      (respReady[p] && respState[p] == '0) |-> respData[p] == '0);
    assert_unasked_no_data_R4: assert property (@(posedge clk) disable iff (!rstN)
      (reqEn[p] && portAvail[p] && !reqNeedsData[p]) |=> respData[p] == '0);
    for (genvar q = 0; q < p; q++) begin : g_q
      assert_lower_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
        (reqEn[q] && (reqAddr[q][OFFSET_LSB +: INDEX_W] % NUM_BANKS)
                  == (reqAddr[p][OFFSET_LSB +: INDEX_W] % NUM_BANKS)) |-> !portAvail[p]);
    end
    if (p > 0) begin : g_tok
      assert_token_order_R3: assert property (@(posedge clk) disable iff (!rstN)
        (respReady[p] && respReady[p-1]) |-> respToken[p] == respToken[p-1] + 1);
    end
  end
endmodule

bind l1d_line_array l1d_line_array_checker #(.NUM_PORTS(NUM_PORTS), .NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/l1d_line_array_test.sv
`timescale 1ns/1ps
module l1d_line_array_test;
  localparam int NP = 2;
  localparam int LB = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]          en, ins, hasD, needD, upd, avail, rdy;
  logic [NP-1:0][7:0]     nst, rst;
  logic [NP-1:0][63:0]    addr, tok, raddr;
  logic [NP-1:0][LB-1:0]  data, rdata;

  l1d_line_array uut (
    .clk(clk), .rstN(rstN), .reqEn(en), .reqInsert(ins), .reqHasData(hasD),
    .reqNeedsData(needD), .reqUpdState(upd), .reqNewState(nst), .reqAddr(addr),
    .reqData(data), .portAvail(avail), .respReady(rdy), .respToken(tok),
    .respAddr(raddr), .respState(rst), .respData(rdata)
  );

  int checks = 0, fails = 0;
  logic [63:0] seq = 0;
  bit done = 0;

  function automatic logic [63:0] mk(input logic [47:0] t, input logic [9:0] s, input logic [5:0] o);
    return {t, s, o};
  endfunction
  function automatic logic [LB-1:0] pat(input logic [31:0] k);
    return {16{k}};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic clearIn();
    en = '0; ins = '0; hasD = '0; needD = '0; upd = '0;
    nst = '0; addr = '0; data = '0;
  endtask

  task automatic setReq(input int p, input bit i, input bit h, input bit n, input bit u,
                        input logic [7:0] s, input logic [63:0] a, input logic [LB-1:0] d);
    en[p] = 1'b1; ins[p] = i; hasD[p] = h; needD[p] = n; upd[p] = u;
    nst[p] = s; addr[p] = a; data[p] = d;
  endtask

  // one request on port 0; response checked against expected state and data
  task automatic single(input bit i, input bit h, input bit n, input bit u, input logic [7:0] s,
                        input logic [63:0] a, input logic [LB-1:0] d,
                        input logic [7:0] expSt, input logic [LB-1:0] expD, input string rq);
    @(negedge clk);
    clearIn();
    setReq(0, i, h, n, u, s, a, d);
    @(posedge clk);
    @(negedge clk);
    clearIn();
    check(rdy[0] == 1'b1, rq, 64'(rdy[0]), 64'd1);
    check(tok[0] == seq, "R3", tok[0], seq);
    check(raddr[0] == a, "R2", raddr[0], a);
    check(rst[0] == expSt, rq, 64'(rst[0]), 64'(expSt));
    check(rdata[0] == expD, rq, rdata[0][63:0], expD[63:0]);
    seq++;
  endtask

  localparam logic [47:0] TA = 48'h111, TB = 48'h222, TC = 48'h333, TE = 48'h444;

  task automatic testReset();
    @(negedge clk);
    check(rdy == '0, "R12", 64'(rdy), 64'd0);
    check(avail == 2'b11, "R12", 64'(avail), 64'd3);
  endtask

  task automatic testMiss();
    single(0, 0, 1, 0, 8'd0, mk(TA, 10'd4, 6'd0), '0, 8'd0, '0, "R5");
  endtask

  task automatic testInsertLookup();
    single(1, 1, 1, 0, 8'd5, mk(TA, 10'd4, 6'd0), pat(32'hAAAA0001), 8'd5, pat(32'hAAAA0001), "R6");
    single(0, 0, 1, 0, 8'd0, mk(TA, 10'd4, 6'h3F), '0, 8'd5, pat(32'hAAAA0001), "R1");
    single(0, 0, 0, 0, 8'd0, mk(TA, 10'd4, 6'd0), '0, 8'd5, '0, "R4");
    single(0, 0, 1, 0, 8'd0, mk(TA ^ 48'h1, 10'd4, 6'd0), '0, 8'd0, '0, "R1");
  endtask

  task automatic testReplace();
    single(1, 1, 0, 0, 8'd6, mk(TB, 10'd4, 6'd0), pat(32'hBBBB0002), 8'd6, '0, "R7");
    single(1, 1, 0, 0, 8'd7, mk(TC, 10'd4, 6'd0), pat(32'hCCCC0003), 8'd7, '0, "R7");
    single(0, 0, 1, 0, 8'd0, mk(TA, 10'd4, 6'd0), '0, 8'd0, '0, "R7");
    single(0, 0, 1, 0, 8'd0, mk(TB, 10'd4, 6'd0), '0, 8'd6, pat(32'hBBBB0002), "R7");
    single(0, 0, 1, 0, 8'd0, mk(TC, 10'd4, 6'd0), '0, 8'd7, pat(32'hCCCC0003), "R7");
  endtask

  task automatic testUpdate();
    single(0, 0, 0, 1, 8'd9, mk(TB, 10'd4, 6'd0), '0, 8'd9, '0, "R8");
    single(0, 0, 1, 0, 8'd0, mk(TB, 10'd4, 6'd0), '0, 8'd9, pat(32'hBBBB0002), "R8");
    single(0, 0, 1, 1, 8'd4, mk(TA, 10'd4, 6'd0), '0, 8'd0, '0, "R8");
    single(0, 0, 1, 0, 8'd0, mk(TA, 10'd4, 6'd0), '0, 8'd0, '0, "R8");
  endtask

  task automatic testInsertKeep();
    single(1, 0, 1, 0, 8'd3, mk(TC, 10'd4, 6'd0), pat(32'hDEAD0000), 8'd3, pat(32'hCCCC0003), "R6");
  endtask

  task automatic testInvalidate();
    single(1, 0, 1, 0, 8'd0, mk(TB, 10'd4, 6'd0), '0, 8'd0, '0, "R9");
    single(0, 0, 1, 0, 8'd0, mk(TB, 10'd4, 6'd0), '0, 8'd0, '0, "R9");
    single(0, 0, 1, 0, 8'd0, mk(TC, 10'd4, 6'd0), '0, 8'd3, pat(32'hCCCC0003), "R9");
  endtask

  task automatic testConflict();
    @(negedge clk);
    clearIn();
    setReq(0, 0, 0, 1, 0, 8'd0, mk(TC, 10'd4, 6'd0), '0);
    setReq(1, 0, 0, 1, 0, 8'd0, mk(TC, 10'd6, 6'd0), '0);
    #1;
    check(avail[0] == 1'b1, "R10", 64'(avail[0]), 64'd1);
    check(avail[1] == 1'b0, "R10", 64'(avail[1]), 64'd0);
    @(posedge clk);
    @(negedge clk);
    clearIn();
    check(rdy == 2'b01, "R10", 64'(rdy), 64'd1);
    check(rst[0] == 8'd3, "R10", 64'(rst[0]), 64'd3);
    check(tok[0] == seq, "R3", tok[0], seq);
    seq++;
  endtask

  task automatic testParallel();
    @(negedge clk);
    clearIn();
    setReq(0, 0, 0, 1, 0, 8'd0, mk(TC, 10'd4, 6'd0), '0);
    setReq(1, 0, 0, 1, 0, 8'd0, mk(TA, 10'd5, 6'd0), '0);
    @(posedge clk);
    @(negedge clk);
    clearIn();
    check(rdy == 2'b11, "R2", 64'(rdy), 64'd3);
    check(tok[0] == seq, "R3", tok[0], seq);
    check(tok[1] == seq + 1, "R3", tok[1], seq + 1);
    check(rst[1] == 8'd0, "R5", 64'(rst[1]), 64'd0);
    check(rdata[0] == pat(32'hCCCC0003), "R4", rdata[0][63:0], 64'hCCCC0003CCCC0003);
    seq += 2;
  endtask

  task automatic testBusy();
    @(negedge clk);
    clearIn();
    setReq(0, 1, 1, 0, 0, 8'd2, mk(TE, 10'd5, 6'd0), pat(32'hEEEE0005));
    @(posedge clk);
    @(negedge clk);
    clearIn();
    check(rdy[0] == 1'b1 && rst[0] == 8'd2, "R6", 64'(rst[0]), 64'd2);
    seq++;
    setReq(0, 0, 0, 1, 0, 8'd0, mk(TE, 10'd5, 6'd0), '0);
    setReq(1, 0, 0, 1, 0, 8'd0, mk(TC, 10'd4, 6'd0), '0);
    #1;
    check(avail[0] == 1'b0, "R11", 64'(avail[0]), 64'd0);
    check(avail[1] == 1'b1, "R11", 64'(avail[1]), 64'd1);
    @(posedge clk);
    @(negedge clk);
    clearIn();
    check(rdy == 2'b10, "R11", 64'(rdy), 64'd2);
    check(tok[1] == seq, "R3", tok[1], seq);
    seq++;
    single(0, 0, 1, 0, 8'd0, mk(TE, 10'd5, 6'd0), '0, 8'd2, pat(32'hEEEE0005), "R11");
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMiss();
    testInsertLookup();
    testReplace();
    testUpdate();
    testInsertKeep();
    testInvalidate();
    testConflict();
    testParallel();
    testBusy();
    done = 1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule